// File: doc/BRIEF.md
# DDR Interface Power-On Sequencer

This block takes a DDR memory subsystem from cold reset to a trained-ready state without software help. A single start pulse launches a fixed chain of steps. The chain holds the PHY, the memory controller and the external memory device in reset, then lets them out one at a time. It enables the SSTL pads, runs impedance calibration and switches on the pad drivers. It then strobes each configuration register in turn, releases the device reset, starts controller initialization and waits out a settle interval. Last, it writes a fixed eight-word pattern that a later training step reads back.

All long waits are counted in ticks of a 100 ns time base. The time base is a prescaler of `TICK_CYC` clock cycles. Short pauses between reset steps are counted in plain cycles. If calibration reports an error, the chain stops in a fail state that holds everything in reset, and a fail counter advances. A new start pulse leaves either the done state or the fail state and runs the chain again from the top.

Top module: `ddrseq_top`

## Requirements
- R1: After `rst`, `phy_rst`=1, `ctl_rst`=1, `dev_rst_n`=0, `sstl_en`=0 and `drv_oe`=0. `done`, `fail`, `fail_cnt` and every strobe (`zcal_start`, `reg_ld`, `init_go`, `mem_we`) are 0.
- R2: A start pulse in idle enters the reset hold on the next edge. The hold keeps `dev_rst_n` low for `DEVRST_TICKS` ticks. Then `PAUSE_CYC` more cycles pass with both resets on. Then `ctl_rst` drops while `phy_rst` stays high for `PAUSE_CYC` cycles. Then `phy_rst` drops and `sstl_en` rises on the same edge.
- R3: `PAUSE_CYC` cycles after the PHY comes up, `zcal_start` pulses for one cycle with `zcal_drv`=`zcal_odt`=7. The sequencer then waits in place until it samples `zcal_busy` low.
- R4: If `zcal_err` is high on the cycle calibration is seen finished, the sequencer enters fail. In fail, `fail`=1, `fail_cnt` increments once, and all pins return to their R1 reset values. No register, init or memory strobe follows.
- R5: On a clean calibration, `drv_oe` becomes 3'b111 on the next edge and stays on: bit 0 is ODT, bit 1 is clock, bit 2 is command. One cycle later `reg_ld` pulses on `CFG_REGS` consecutive cycles with `reg_idx` counting 0 upward. Index 0 is the configuration register, 1 is refresh, 2 to 5 are timing 0 to 3, and 6 to 9 are mode 0 to 3.
- R6: After the last register strobe, `dev_rst_n` goes high and is held for `DEVRST_TICKS` ticks. Only then does `init_go` pulse for one cycle.
- R7: The sequencer waits for `init_done`, then waits `SETTLE_TICKS` ticks. It then writes on 8 consecutive cycles with `mem_we`=1 to byte addresses 0x00, 0x04, … 0x1C. The data in that order is CACAFEFE, 22221111, 44443333, 66665555, 88887777, AAAA9999, CCCCBBBB, EEEEDDDD.
- R8: After the last write, `done` rises and stays high. The pads stay in the running configuration until the next start.
- R9: A start pulse while the chain is running has no effect on any output.
- R10: `fail` and `done` stay set until a start pulse. That pulse clears them and reruns the whole chain from R2. `fail_cnt` is kept across runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up chain |
| zcal_busy | input | 1 | Calibration still running (PHY clears it when finished) |
| zcal_err | input | 1 | Calibration error status, valid when busy is low |
| init_done | input | 1 | Controller reports memory initialization finished |
| phy_rst | output | 1 | PHY reset |
| ctl_rst | output | 1 | Forced controller reset |
| dev_rst_n | output | 1 | Memory device reset, active low |
| sstl_en | output | 1 | SSTL pad enable |
| drv_oe | output | 3 | Output enables: ODT, clock, command |
| zcal_start | output | 1 | One-cycle calibration kick |
| zcal_drv | output | CODE_W | Drive-strength code |
| zcal_odt | output | CODE_W | ODT code |
| reg_ld | output | 1 | Configuration register load strobe |
| reg_idx | output | clog2(CFG_REGS) | Register selected by the strobe |
| init_go | output | 1 | One-cycle memory initialization trigger |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Write data |
| done | output | 1 | Chain completed |
| fail | output | 1 | Chain aborted on calibration error |
| fail_cnt | output | FCNT_W | Number of aborts since reset |

## Verification
The properties assume `zcal_busy` is high by the first cycle after the calibration kick. They also assume `zcal_err` is meaningful only once busy is low, and that `init_done` is low from the cycle after `init_go` until the controller finishes. The bench models the PHY and controller as registered responders that raise busy and lower done on the edge that samples the kick. They release busy and raise done after a chosen latency, so these assumptions hold in every run. Start is pulsed only for single cycles. One of those pulses lands mid-chain so the ignore rule is exercised.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

  // Order matters: the run states from ST_CTLUP to ST_DONE are contiguous
  // so the pin decoder can use range compares.
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_HOLD    = 4'd1,
    ST_GAP     = 4'd2,
    ST_CTLUP   = 4'd3,
    ST_PHYUP   = 4'd4,
    ST_CALGO   = 4'd5,
    ST_CALWT   = 4'd6,
    ST_DRVON   = 4'd7,
    ST_CFG     = 4'd8,
    ST_DEVUP   = 4'd9,
    ST_INITGO  = 4'd10,
    ST_INITWT  = 4'd11,
    ST_SETTLE  = 4'd12,
    ST_PRELOAD = 4'd13,
    ST_DONE    = 4'd14,
    ST_FAIL    = 4'd15
  } seq_st_e;

  localparam int unsigned PRELOAD_WORDS = 8;
  localparam int unsigned WORD_W        = 32;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Word k (k>0) repeats hex digit 2k in the upper half and 2k-1 in the lower.
  function automatic logic [WORD_W-1:0] preload_word(input logic [2:0] k);
    logic [3:0] lo;
    logic [3:0] hi;
    hi = {k, 1'b0};
    lo = hi - 4'd1;
    if (k == 3'd0) return 32'hCACA_FEFE;
    return {{4{hi}}, {4{lo}}};
  endfunction

endpackage

// File: rtl/ddrseq_delay.sv
module ddrseq_delay #(
  parameter int CNT_W    = 14,
  parameter int TICK_CYC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             use_tick,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_CYC - 1);

  logic [CNT_W-1:0] units_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      units_q     <= '0;
      pre_q       <= '0;
      tick_mode_q <= 1'b0;
    end else if (load) begin
      units_q     <= len - CNT_W'(1);
      pre_q       <= use_tick ? PRE_TOP : '0;
      tick_mode_q <= use_tick;
    end else if (pre_q == '0) begin
      if (units_q != '0) units_q <= units_q - CNT_W'(1);
      pre_q <= tick_mode_q ? PRE_TOP : '0;
    end else begin
      pre_q <= pre_q - PRE_W'(1);
    end
  end

  // The window ends on the final cycle of the final unit.
  assign last = (units_q == '0) && (pre_q == '0);

endmodule

// File: rtl/ddrseq_fsm.sv
module ddrseq_fsm
  import ddrseq_pkg::*;
#(
  parameter int CNT_W        = 14,
  parameter int STEP_W       = 4,
  parameter int PAUSE_CYC    = 8,
  parameter int DEVRST_TICKS = 10000,
  parameter int SETTLE_TICKS = 10000,
  parameter int CFG_REGS     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dly_last,
  input  logic              zcal_busy,
  input  logic              zcal_err,
  input  logic              init_done,
  output seq_st_e           st_q,
  output seq_st_e           st_d,
  output logic [STEP_W-1:0] step_d,
  output logic              dly_load,
  output logic              dly_tick,
  output logic [CNT_W-1:0]  dly_len
);
  localparam logic [STEP_W-1:0] CFG_LAST  = STEP_W'(CFG_REGS - 1);
  localparam logic [STEP_W-1:0] WORD_LAST = STEP_W'(PRELOAD_WORDS - 1);

  logic [STEP_W-1:0] step_q;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start) st_d = ST_HOLD;
      ST_HOLD:   if (dly_last) st_d = ST_GAP;
      ST_GAP:    if (dly_last) st_d = ST_CTLUP;
      ST_CTLUP:  if (dly_last) st_d = ST_PHYUP;
      ST_PHYUP:  if (dly_last) st_d = ST_CALGO;
      ST_CALGO:  st_d = ST_CALWT;
      ST_CALWT:  if (!zcal_busy) st_d = zcal_err ? ST_FAIL : ST_DRVON;
      ST_DRVON: begin
        st_d   = ST_CFG;
        step_d = '0;
      end
      ST_CFG: begin
        if (step_q == CFG_LAST) st_d = ST_DEVUP;
        else step_d = step_q + STEP_W'(1);
      end
      ST_DEVUP:  if (dly_last) st_d = ST_INITGO;
      ST_INITGO: st_d = ST_INITWT;
      ST_INITWT: if (init_done) st_d = ST_SETTLE;
      ST_SETTLE: begin
        if (dly_last) begin
          st_d   = ST_PRELOAD;
          step_d = '0;
        end
      end
      ST_PRELOAD: begin
        if (step_q == WORD_LAST) st_d = ST_DONE;
        else step_d = step_q + STEP_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Delay window is armed on entry to each timed state.
  always_comb begin
    dly_load = (st_d != st_q);
    dly_tick = 1'b0;
    dly_len  = CNT_W'(1);
    case (st_d)
      ST_HOLD, ST_DEVUP: begin
        dly_tick = 1'b1;
        dly_len  = CNT_W'(DEVRST_TICKS);
      end
      ST_SETTLE: begin
        dly_tick = 1'b1;
        dly_len  = CNT_W'(SETTLE_TICKS);
      end
      ST_GAP, ST_CTLUP, ST_PHYUP: dly_len = CNT_W'(PAUSE_CYC);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/ddrseq_outreg.sv
module ddrseq_outreg
  import ddrseq_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 5,
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_e           st_q,
  input  seq_st_e           st_d,
  input  logic [STEP_W-1:0] step_d,
  output logic              phy_rst,
  output logic              ctl_rst,
  output logic              dev_rst_n,
  output logic              sstl_en,
  output logic [2:0]        drv_oe,
  output logic              zcal_start,
  output logic              reg_ld,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              init_go,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic              fail,
  output logic [FCNT_W-1:0] fail_cnt
);
  logic in_run;
  logic phy_up, drv_up, dev_up;

  // Pins are decoded from the next state so they change on the same edge
  // as the state register and still come straight out of flops.
  always_comb begin
    in_run = (st_d >= ST_CTLUP) && (st_d <= ST_DONE);
    phy_up = (st_d >= ST_PHYUP) && (st_d <= ST_DONE);
    drv_up = (st_d >= ST_DRVON) && (st_d <= ST_DONE);
    dev_up = (st_d >= ST_DEVUP) && (st_d <= ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_rst    <= 1'b1;
      ctl_rst    <= 1'b1;
      dev_rst_n  <= 1'b0;
      sstl_en    <= 1'b0;
      drv_oe     <= '0;
      zcal_start <= 1'b0;
      reg_ld     <= 1'b0;
      reg_idx    <= '0;
      init_go    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_cnt   <= '0;
    end else begin
      ctl_rst    <= !in_run;
      phy_rst    <= !phy_up;
      sstl_en    <= phy_up;
      drv_oe     <= {3{drv_up}};
      dev_rst_n  <= dev_up;
      zcal_start <= (st_d == ST_CALGO);
      init_go    <= (st_d == ST_INITGO);
      reg_ld     <= (st_d == ST_CFG);
      reg_idx    <= (st_d == ST_CFG) ? IDX_W'(step_d) : '0;
      mem_we     <= (st_d == ST_PRELOAD);
      mem_addr   <= (st_d == ST_PRELOAD) ? ADDR_W'({step_d, 2'b00}) : '0;
      mem_wdata  <= (st_d == ST_PRELOAD) ? preload_word(step_d[2:0]) : '0;
      done       <= (st_d == ST_DONE);
      fail       <= (st_d == ST_FAIL);
      if (st_d == ST_FAIL && st_q != ST_FAIL) fail_cnt <= fail_cnt + FCNT_W'(1);
    end
  end

endmodule

// File: rtl/ddrseq_top.sv
module ddrseq_top
  import ddrseq_pkg::*;
#(
  parameter int TICK_CYC     = 20,
  parameter int PAUSE_CYC    = 8,
  parameter int DEVRST_TICKS = 10000,
  parameter int SETTLE_TICKS = 10000,
  parameter int CFG_REGS     = 10,
  parameter int CODE_W       = 3,
  parameter int DRV_CODE     = 7,
  parameter int ODT_CODE     = 7,
  parameter int ADDR_W       = 5,
  parameter int FCNT_W       = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        zcal_busy,
  input  logic                        zcal_err,
  input  logic                        init_done,
  output logic                        phy_rst,
  output logic                        ctl_rst,
  output logic                        dev_rst_n,
  output logic                        sstl_en,
  output logic [2:0]                  drv_oe,
  output logic                        zcal_start,
  output logic [CODE_W-1:0]           zcal_drv,
  output logic [CODE_W-1:0]           zcal_odt,
  output logic                        reg_ld,
  output logic [$clog2(CFG_REGS)-1:0] reg_idx,
  output logic                        init_go,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [31:0]                 mem_wdata,
  output logic                        done,
  output logic                        fail,
  output logic [FCNT_W-1:0]           fail_cnt
);
  localparam int MAX_LEN = imax(imax(DEVRST_TICKS, SETTLE_TICKS), PAUSE_CYC);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int STEP_W  = $clog2(imax(CFG_REGS, PRELOAD_WORDS));
  localparam int IDX_W   = $clog2(CFG_REGS);

  seq_st_e           st_q, st_d;
  logic [STEP_W-1:0] step_d;
  logic              dly_load, dly_tick, dly_last;
  logic [CNT_W-1:0]  dly_len;

  assign zcal_drv = CODE_W'(DRV_CODE);
  assign zcal_odt = CODE_W'(ODT_CODE);

  ddrseq_fsm #(
    .CNT_W(CNT_W), .STEP_W(STEP_W), .PAUSE_CYC(PAUSE_CYC),
    .DEVRST_TICKS(DEVRST_TICKS), .SETTLE_TICKS(SETTLE_TICKS), .CFG_REGS(CFG_REGS)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .dly_last(dly_last),
    .zcal_busy(zcal_busy), .zcal_err(zcal_err), .init_done(init_done),
    .st_q(st_q), .st_d(st_d), .step_d(step_d),
    .dly_load(dly_load), .dly_tick(dly_tick), .dly_len(dly_len)
  );

  ddrseq_delay #(.CNT_W(CNT_W), .TICK_CYC(TICK_CYC)) u_dly (
    .clk(clk), .rst(rst), .load(dly_load), .use_tick(dly_tick),
    .len(dly_len), .last(dly_last)
  );

  ddrseq_outreg #(
    .STEP_W(STEP_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .FCNT_W(FCNT_W)
  ) u_out (
    .clk(clk), .rst(rst), .st_q(st_q), .st_d(st_d), .step_d(step_d),
    .phy_rst(phy_rst), .ctl_rst(ctl_rst), .dev_rst_n(dev_rst_n),
    .sstl_en(sstl_en), .drv_oe(drv_oe), .zcal_start(zcal_start),
    .reg_ld(reg_ld), .reg_idx(reg_idx), .init_go(init_go),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .fail(fail), .fail_cnt(fail_cnt)
  );

endmodule

// File: rtl/ddrseq_chk.sv
module ddrseq_chk #(
  parameter int FCNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              zcal_busy,
  input logic              zcal_err,
  input logic              phy_rst,
  input logic              ctl_rst,
  input logic              dev_rst_n,
  input logic              sstl_en,
  input logic [2:0]        drv_oe,
  input logic              zcal_start,
  input logic              reg_ld,
  input logic              init_go,
  input logic              mem_we,
  input logic              done,
  input logic              fail,
  input logic [FCNT_W-1:0] fail_cnt
);
  // R2: the PHY never leaves reset while the controller is still held
  p_phy_after_ctl_r2: assert property (@(posedge clk) disable iff (rst)
    !phy_rst |-> !ctl_rst);

  // R2: pads come up on the edge that releases the PHY
  p_sstl_with_phy_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_rst) |-> $rose(sstl_en));

  // R3: drivers switch on only after a clean, finished calibration
  p_drv_after_cal_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_oe[0]) |-> (!$past(zcal_busy) && !$past(zcal_err)));

  // R4: each entry to fail bumps the counter by exactly one
  p_fail_count_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (fail_cnt == $past(fail_cnt) + FCNT_W'(1)));

  // R4: fail holds every reset and issues no strobes
  p_fail_safe_r4: assert property (@(posedge clk) disable iff (rst)
    fail |-> (phy_rst && ctl_rst && !dev_rst_n && !reg_ld && !init_go && !mem_we));

  // R5: one strobe at a time
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({zcal_start, reg_ld, init_go, mem_we}));

  // R6: init only with the device out of reset and all drivers on
  p_init_ready_r6: assert property (@(posedge clk) disable iff (rst)
    init_go |-> (dev_rst_n && drv_oe == 3'b111));

  // R7: preload writes only into a live interface
  p_write_live_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (dev_rst_n && sstl_en && !phy_rst));

  // R8: done persists until a start arrives
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

endmodule

bind ddrseq_top ddrseq_chk #(.FCNT_W(FCNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .zcal_busy(zcal_busy), .zcal_err(zcal_err),
  .phy_rst(phy_rst), .ctl_rst(ctl_rst), .dev_rst_n(dev_rst_n), .sstl_en(sstl_en),
  .drv_oe(drv_oe), .zcal_start(zcal_start), .reg_ld(reg_ld), .init_go(init_go),
  .mem_we(mem_we), .done(done), .fail(fail), .fail_cnt(fail_cnt)
);

// File: tb/sim_ddrseq_top.sv
`timescale 1ns/1ps
module sim_ddrseq_top;
  localparam int TCK    = 2;
  localparam int PAUSE  = 8;
  localparam int DEVT   = 5;
  localparam int SETT   = 7;
  localparam int NREG   = 10;
  localparam int HOLD_C = DEVT * TCK;
  localparam int SETL_C = SETT * TCK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic zcal_busy = 1'b0;
  logic zcal_err = 1'b0;
  logic init_done = 1'b0;

  logic phy_rst, ctl_rst, dev_rst_n, sstl_en, zcal_start, reg_ld, init_go, mem_we, done, fail;
  logic [2:0]  drv_oe, zcal_drv, zcal_odt;
  logic [3:0]  reg_idx;
  logic [4:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [7:0]  fail_cnt;

  always #2.5 clk = ~clk;

  ddrseq_top #(.TICK_CYC(TCK), .PAUSE_CYC(PAUSE), .DEVRST_TICKS(DEVT),
               .SETTLE_TICKS(SETT), .CFG_REGS(NREG)) u0 (
    .clk(clk), .rst(rst), .start(start), .zcal_busy(zcal_busy), .zcal_err(zcal_err),
    .init_done(init_done), .phy_rst(phy_rst), .ctl_rst(ctl_rst), .dev_rst_n(dev_rst_n),
    .sstl_en(sstl_en), .drv_oe(drv_oe), .zcal_start(zcal_start), .zcal_drv(zcal_drv),
    .zcal_odt(zcal_odt), .reg_ld(reg_ld), .reg_idx(reg_idx), .init_go(init_go),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
    .fail(fail), .fail_cnt(fail_cnt)
  );

  // PHY and controller responders
  int cal_len = 1, init_len = 1, cal_left = 0, init_left = 0;
  always @(posedge clk) begin
    if (zcal_start) begin
      zcal_busy <= 1'b1;
      cal_left  <= cal_len;
    end else if (zcal_busy) begin
      if (cal_left == 1) zcal_busy <= 1'b0;
      cal_left <= cal_left - 1;
    end
    if (init_go) begin
      init_done <= 1'b0;
      init_left <= init_len;
    end else if (init_left > 0) begin
      if (init_left == 1) init_done <= 1'b1;
      init_left <= init_left - 1;
    end
  end

  // Expected pin values
  logic e_phy, e_ctl, e_devn, e_sstl, e_zs, e_ld, e_go, e_we, e_done, e_fail;
  logic [2:0] e_oe;
  logic [3:0] e_idx;
  logic [4:0] e_addr;
  logic [31:0] e_wd;
  logic [7:0] e_fcnt;
  string e_req = "R1";
  int checks = 0, errors = 0;
  bit chk_en = 1'b0, finished = 1'b0;

  logic [31:0] pat [8];
  initial begin
    pat[0] = 32'hCACAFEFE; pat[1] = 32'h22221111; pat[2] = 32'h44443333; pat[3] = 32'h66665555;
    pat[4] = 32'h88887777; pat[5] = 32'hAAAA9999; pat[6] = 32'hCCCCBBBB; pat[7] = 32'hEEEEDDDD;
  end

  task automatic pins(input logic p, input logic c, input logic dn, input logic s, input logic [2:0] oe);
    e_phy = p; e_ctl = c; e_devn = dn; e_sstl = s; e_oe = oe;
    e_zs = 0; e_ld = 0; e_idx = 0; e_go = 0; e_we = 0; e_addr = 0; e_wd = 0;
    e_done = 0; e_fail = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      logic [63:0] a, x;
      a = {phy_rst, ctl_rst, dev_rst_n, sstl_en, drv_oe, zcal_start, zcal_drv, zcal_odt,
           reg_ld, reg_idx, init_go, mem_we, mem_addr, done, fail, fail_cnt, 16'h0};
      x = {e_phy, e_ctl, e_devn, e_sstl, e_oe, e_zs, 3'd7, 3'd7,
           e_ld, e_idx, e_go, e_we, e_addr, e_done, e_fail, e_fcnt, 16'h0};
      checks++;
      if (a !== x || mem_wdata !== e_wd) begin
        errors++;
        $display("FAIL %s t=%0t pins act=%h exp=%h wdata act=%h exp=%h",
                 e_req, $time, a, x, mem_wdata, e_wd);
      end
    end
  end

  task automatic run(input int lc, input int li, input bit err, input bit glitch);
    cal_len = lc; init_len = li; zcal_err = err;
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    pins(1, 1, 0, 0, 0); e_req = "R2"; cyc(HOLD_C);          // device reset hold
    cyc(PAUSE);                                              // both resets still on
    pins(1, 0, 0, 0, 0); cyc(PAUSE);                         // controller out
    pins(0, 0, 0, 1, 0);
    if (glitch) begin
      e_req = "R9"; start = 1'b1; cyc(1); start = 1'b0; cyc(PAUSE - 1);
    end else cyc(PAUSE);
    e_req = "R3"; e_zs = 1; cyc(1);
    e_zs = 0; cyc(lc + 1);
    if (err) begin
      pins(1, 1, 0, 0, 0); e_fail = 1; e_fcnt = e_fcnt + 1; e_req = "R4";
      return;
    end
    e_req = "R5"; pins(0, 0, 0, 1, 3'b111); cyc(1);
    for (int k = 0; k < NREG; k++) begin
      e_ld = 1; e_idx = 4'(k); cyc(1);
    end
    e_req = "R6"; pins(0, 0, 1, 1, 3'b111); cyc(HOLD_C);
    e_go = 1; cyc(1);
    e_go = 0; e_req = "R7"; cyc(li + 1);
    cyc(SETL_C);
    for (int k = 0; k < 8; k++) begin
      e_we = 1; e_addr = 5'(4 * k); e_wd = pat[k]; cyc(1);
    end
    pins(0, 0, 1, 1, 3'b111); e_done = 1; e_req = "R8";
  endtask

  initial begin
    pins(1, 1, 0, 0, 0); e_fcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1", {phy_rst, ctl_rst, dev_rst_n, sstl_en, drv_oe, done, fail} === 9'b110_0000_00,
          {phy_rst, ctl_rst, dev_rst_n, sstl_en, drv_oe, done, fail}, 9'b110_0000_00);
    check("R1", fail_cnt === 8'd0 && !mem_we && !reg_ld && !init_go && !zcal_start,
          fail_cnt, 0);
    chk_en = 1'b1; e_req = "R1";
    cyc(5);
    run(3, 4, 1'b0, 1'b1);                         // R2..R9 with mid-run start
    cyc(6);
    check("R8", done === 1'b1, done, 1);
    e_req = "R10"; run(1, 1, 1'b0, 1'b0);          // restart from done
    cyc(4);
    run(2, 2, 1'b1, 1'b0);                         // calibration error
    cyc(6);
    check("R4", fail === 1'b1 && fail_cnt === 8'd1, {fail, fail_cnt}, 9'h101);
    run(4, 3, 1'b0, 1'b0);                         // restart from fail
    cyc(4);
    check("R10", fail === 1'b0 && done === 1'b1 && fail_cnt === 8'd1,
          {fail, done, fail_cnt}, 10'h101);
    chk_en = 1'b0;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired in %s", e_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule